// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block serves the transmit side of one logical channel. It walks a ring of descriptors that the host has placed in memory. A descriptor is used only when the host has set its ownership bit. The engine fetches that descriptor's buffer one byte at a time and sends the bytes to a downstream framer, following chained descriptors until it reaches the one flagged as frame end. It then rewrites each descriptor the frame used with the ownership bit cleared, which returns it to the host, and moves its current pointer past the frame.

A frame starts only while the channel's context reports the channel as both active and ready to transmit. When the descriptor under the pointer is still owned by the host, the engine backs off for a programmable number of cycles before it reads that descriptor again. A descriptor with a zero byte count aborts the frame and sets a sticky error flag.

Top module: `tdr_tx_ring`

## Requirements
- R1: A new frame is begun only from idle while `chan_active` and `tx_ready` are both 1. While either is 0 in idle, the block issues no memory access, sends no byte and leaves `cur_idx` unchanged.
- R2: Descriptor i occupies word `ring_base + 2*i` (control) and the word after it (buffer word address in its low ADDR_W bits). In the control word, bit 31 is ownership (1 = engine may use it), bit 30 is frame end, and bits 11:0 are the byte count. A descriptor whose ownership bit is 0 produces no output.
- R3: After reading a descriptor that is not owned, the block issues no further memory read for at least `poll_gap`+1 cycles. It then reads that descriptor again, and starts the frame once ownership appears.
- R4: Byte k of a buffer is taken from word `buffer + k/4`, lane k mod 4, and lane 0 is bits 7:0. Bytes go out in increasing k, one per `tx_valid` pulse.
- R5: A frame spans consecutive descriptors up to and including the first one with frame end set. `tx_last` is 1 only with the final byte of that descriptor.
- R6: After the last byte of a frame, each descriptor the frame used has its control word rewritten with bit 31 cleared and all other bits kept.
- R7: When a frame completes, `cur_idx` becomes the index after its frame-end descriptor, wrapping from RING_LEN-1 to 0. It changes only as the block returns to idle.
- R8: A descriptor with byte count 0 aborts the frame. The block pulses `tx_abort`, sets `err_flag` (sticky until reset), hands back every descriptor up to and including the bad one, and moves `cur_idx` past it. No `tx_last` is sent for that frame.
- R9: A chained descriptor that is not yet owned stalls the frame in progress, with `busy` held at 1, until the host sets its ownership bit. The frame then continues with no abort.
- R10: Ownership is returned by a read of the control word followed on the next cycle by a write to the same address. `mem_rd` and `mem_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_active | input | 1 | Channel enabled flag from the context entry |
| tx_ready | input | 1 | Transmit-ready flag from the context entry |
| ring_base | input | ADDR_W | Word address of descriptor 0 |
| poll_gap | input | POLL_W | Back-off cycles before re-reading a descriptor that is not owned |
| mem_rd | output | 1 | Memory read strobe; data is returned one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after `mem_rd` |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_abort | output | 1 | One-cycle pulse: the current frame is discarded |
| cur_idx | output | $clog2(RING_LEN) | Index of the descriptor at which the next frame starts |
| err_flag | output | 1 | Sticky zero-count error |
| busy | output | 1 | Engine is not idle |

## Verification
The bench drives the frames that span several descriptors and cross the end of the ring. A design that wraps the pointer wrongly, or that raises `tx_last` on a middle descriptor, shows up as a mismatch against the expected byte queue or against the final `cur_idx`. A chained descriptor that is withheld mid-frame exposes an engine that aborts, skips ahead or returns to idle before the host releases it. A zero-count descriptor after a byte-carrying one shows whether the abort pulse, the sticky error and the hand-back of both descriptors happen. Holding the gating flags low with an owned descriptor present, and keeping a descriptor unowned for a long window, catches an engine that ignores the context flags or polls memory without backing off.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_D0_REQ,
      S_D0_CHK,
      S_D1_REQ,
      S_D1_GET,
      S_B_REQ,
      S_B_GET,
      S_WAIT,
      S_H_REQ,
      S_H_WR
   } tdr_state_e;

endpackage

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr #(
   parameter int RING_LEN = 4
) (
   input  logic [$clog2(RING_LEN)-1:0] idx,
   output logic [$clog2(RING_LEN)-1:0] nxt
);
   localparam int IDX_W = $clog2(RING_LEN);

   generate
      if ((1 << IDX_W) == RING_LEN) begin : g_pow2
         // natural wrap of the counter width
         assign nxt = idx + 1'b1;
      end else begin : g_cmp
         assign nxt = (idx == IDX_W'(RING_LEN - 1)) ? '0 : idx + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tdr_poll_timer.sv
module tdr_poll_timer #(
   parameter int POLL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [POLL_W-1:0] gap,
   output logic              expired
);
   logic [POLL_W-1:0] cnt_q;
   logic              run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= gap;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/tdr_lane_sel.sv
module tdr_lane_sel #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]              word,
   input  logic [$clog2(DATA_W/8)-1:0]    lane,
   output logic [7:0]                     byte_o
);
   localparam int LANES = DATA_W / 8;

   logic [7:0] lanes [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lanes[g] = word[8*g +: 8];
      end
   endgenerate

   assign byte_o = lanes[lane];
endmodule

// File: rtl/tdr_tx_ring.sv
module tdr_tx_ring
   import tdr_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int RING_LEN = 4,
   parameter int CNT_W    = 12,
   parameter int POLL_W   = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        chan_active,
   input  logic                        tx_ready,
   input  logic [ADDR_W-1:0]           ring_base,
   input  logic [POLL_W-1:0]           poll_gap,
   output logic                        mem_rd,
   output logic                        mem_wr,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [DATA_W-1:0]           mem_wdata,
   input  logic [DATA_W-1:0]           mem_rdata,
   output logic                        tx_valid,
   output logic [7:0]                  tx_data,
   output logic                        tx_last,
   output logic                        tx_abort,
   output logic [$clog2(RING_LEN)-1:0] cur_idx,
   output logic                        err_flag,
   output logic                        busy
);
   localparam int LANES = DATA_W / 8;
   localparam int LSB_W = $clog2(LANES);
   localparam int IDX_W = $clog2(RING_LEN);
   localparam int ND_W  = $clog2(RING_LEN + 1);
   localparam int OWN_B = DATA_W - 1;
   localparam int EOF_B = DATA_W - 2;

   // elaboration-time parameter checks
   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
         $error("tdr_tx_ring: DATA_W must be a multiple of 8 and at least 16");
      end
      if (RING_LEN < 2) begin : g_bad_ring
         $error("tdr_tx_ring: RING_LEN must be at least 2");
      end
      if (CNT_W > DATA_W - 2) begin : g_bad_cnt
         $error("tdr_tx_ring: CNT_W overlaps the flag bits");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("tdr_tx_ring: ADDR_W wider than a data word");
      end
   endgenerate

   tdr_state_e        st;
   logic [IDX_W-1:0]  cur_q, widx, hidx, widx_nx, hidx_nx;
   logic [ND_W-1:0]   ndesc;
   logic              eof_q;
   logic [CNT_W-1:0]  cnt_q, bidx;
   logic [ADDR_W-1:0] buf_q;
   logic              poll_load, poll_done;
   logic [7:0]        lane_byte;
   logic [ADDR_W-1:0] d0w, d0h, bwa;
   logic              rd_own, rd_eof, at_end;
   logic [CNT_W-1:0]  rd_cnt;
   logic              tv_q, tl_q, ta_q, err_q;
   logic [7:0]        td_q;

   tdr_ring_ptr #(.RING_LEN(RING_LEN)) u_wnext (.idx(widx), .nxt(widx_nx));
   tdr_ring_ptr #(.RING_LEN(RING_LEN)) u_hnext (.idx(hidx), .nxt(hidx_nx));

   tdr_poll_timer #(.POLL_W(POLL_W)) u_poll (
      .clk(clk), .rst_n(rst_n), .load(poll_load), .gap(poll_gap), .expired(poll_done)
   );

   tdr_lane_sel #(.DATA_W(DATA_W)) u_lane (
      .word(mem_rdata), .lane(bidx[LSB_W-1:0]), .byte_o(lane_byte)
   );

   assign d0w    = ring_base + ADDR_W'({widx, 1'b0});
   assign d0h    = ring_base + ADDR_W'({hidx, 1'b0});
   assign bwa    = buf_q + ADDR_W'(bidx >> LSB_W);
   assign rd_own = mem_rdata[OWN_B];
   assign rd_eof = mem_rdata[EOF_B];
   assign rd_cnt = mem_rdata[CNT_W-1:0];
   assign at_end = (bidx == cnt_q - 1'b1);
   assign poll_load = (st == S_D0_CHK) && !rd_own;

   always_comb begin
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = d0w;
      mem_wdata = {1'b0, mem_rdata[DATA_W-2:0]};
      case (st)
         S_D0_REQ: mem_rd = 1'b1;
         S_D1_REQ: begin mem_rd = 1'b1; mem_addr = d0w + 1'b1; end
         S_B_REQ:  begin mem_rd = 1'b1; mem_addr = bwa;        end
         S_H_REQ:  begin mem_rd = 1'b1; mem_addr = d0h;        end
         S_H_WR:   begin mem_wr = 1'b1; mem_addr = d0h;        end
         default:  ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         cur_q <= '0;
         widx  <= '0;
         hidx  <= '0;
         ndesc <= '0;
         eof_q <= 1'b0;
         cnt_q <= '0;
         bidx  <= '0;
         buf_q <= '0;
         tv_q  <= 1'b0;
         tl_q  <= 1'b0;
         ta_q  <= 1'b0;
         td_q  <= '0;
         err_q <= 1'b0;
      end else begin
         tv_q <= 1'b0;
         tl_q <= 1'b0;
         ta_q <= 1'b0;
         case (st)
            S_IDLE: if (chan_active && tx_ready) begin
               widx  <= cur_q;
               ndesc <= '0;
               st    <= S_D0_REQ;
            end
            S_D0_REQ: st <= S_D0_CHK;
            S_D0_CHK: begin
               if (!rd_own) begin
                  st <= S_WAIT;
               end else begin
                  ndesc <= ndesc + 1'b1;
                  eof_q <= rd_eof;
                  cnt_q <= rd_cnt;
                  if (rd_cnt == '0) begin
                     err_q <= 1'b1;
                     ta_q  <= 1'b1;
                     widx  <= widx_nx;
                     hidx  <= cur_q;
                     st    <= S_H_REQ;
                  end else begin
                     st <= S_D1_REQ;
                  end
               end
            end
            S_D1_REQ: st <= S_D1_GET;
            S_D1_GET: begin
               buf_q <= mem_rdata[ADDR_W-1:0];
               bidx  <= '0;
               st    <= S_B_REQ;
            end
            S_B_REQ: st <= S_B_GET;
            S_B_GET: begin
               tv_q <= 1'b1;
               td_q <= lane_byte;
               tl_q <= eof_q && at_end;
               bidx <= bidx + 1'b1;
               if (at_end) begin
                  widx <= widx_nx;
                  if (eof_q) begin
                     hidx <= cur_q;
                     st   <= S_H_REQ;
                  end else begin
                     st   <= S_D0_REQ;
                  end
               end else begin
                  st <= S_B_REQ;
               end
            end
            S_WAIT: if (poll_done) st <= (ndesc == '0) ? S_IDLE : S_D0_REQ;
            S_H_REQ: st <= S_H_WR;
            S_H_WR: begin
               hidx  <= hidx_nx;
               ndesc <= ndesc - 1'b1;
               if (ndesc == ND_W'(1)) begin
                  cur_q <= widx;
                  st    <= S_IDLE;
               end else begin
                  st <= S_H_REQ;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign tx_valid = tv_q;
   assign tx_data  = td_q;
   assign tx_last  = tl_q;
   assign tx_abort = ta_q;
   assign cur_idx  = cur_q;
   assign err_flag = err_q;
   assign busy     = (st != S_IDLE);
endmodule

// File: rtl/tdr_ring_chk.sv
module tdr_ring_chk #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int RING_LEN = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        chan_active,
   input logic                        tx_ready,
   input logic                        mem_rd,
   input logic                        mem_wr,
   input logic [ADDR_W-1:0]           mem_addr,
   input logic [DATA_W-1:0]           mem_wdata,
   input logic                        tx_valid,
   input logic                        tx_last,
   input logic                        tx_abort,
   input logic [$clog2(RING_LEN)-1:0] cur_idx,
   input logic                        err_flag,
   input logic                        busy
);
   // R10: the memory port never reads and writes in the same cycle
   a_r10_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R10: every write-back follows a read of the same word
   a_r10_rmw: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

   // R6: a write-back always returns ownership
   a_r6_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> !mem_wdata[DATA_W-1]);

   // R1: idle with a gating flag low stays idle
   a_r1_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(chan_active && tx_ready)) |=> !busy);

   // R5: frame end marks a valid byte
   a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   // R8: abort carries no byte, and the error is raised with it and stays
   a_r8_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |-> (!tx_valid && err_flag));
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R7: the pointer stays in the ring and only moves when returning to idle
   a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cur_idx) < RING_LEN);
   a_r7_idx_move: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_idx) |-> $fell(busy));
endmodule

bind tdr_tx_ring tdr_ring_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RING_LEN(RING_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_active(chan_active), .tx_ready(tx_ready),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .tx_valid(tx_valid), .tx_last(tx_last), .tx_abort(tx_abort),
   .cur_idx(cur_idx), .err_flag(err_flag), .busy(busy)
);

// File: tb/tdr_tx_ring_test.sv
`timescale 1ns/1ps
module tdr_tx_ring_test;
   localparam int RB  = 16;
   localparam int GAP = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_active = 1'b0, tx_ready = 1'b0;
   logic [15:0] ring_base = 16'(RB);
   logic [7:0]  poll_gap = 8'(GAP);
   logic        mem_rd, mem_wr;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        tx_valid, tx_last, tx_abort, err_flag, busy;
   logic [7:0]  tx_data;
   logic [1:0]  cur_idx;

   logic [31:0] mem [0:255];
   logic [8:0]  exp_q [$];
   int          tests = 0, fails = 0, cycles = 0;
   int          aborts = 0, gated_rd = 0, rd_cnt = 0;
   bit          gate_off = 1'b0;

   always #4 clk = ~clk;

   tdr_tx_ring uut (
      .clk(clk), .rst_n(rst_n), .chan_active(chan_active), .tx_ready(tx_ready),
      .ring_base(ring_base), .poll_gap(poll_gap),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_abort(tx_abort),
      .cur_idx(cur_idx), .err_flag(err_flag), .busy(busy)
   );

   // memory with one cycle of read latency
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int j);
      return 8'(seed * 7 + j * 13 + 1);
   endfunction

   function automatic logic [31:0] ctl(input bit own, input bit eof, input int cnt);
      return {own, eof, 18'd0, 12'(cnt)};
   endfunction

   // reference model: every byte leaving the block is compared on each clock
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (tx_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5", "unexpected byte", int'(tx_data), -1);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk(tx_data == e[7:0], "R4", "byte value", int'(tx_data), int'(e[7:0]));
               chk(tx_last == e[8], "R5", "last flag", int'(tx_last), int'(e[8]));
            end
         end
         if (tx_abort) aborts++;
         if (gate_off && mem_rd) gated_rd++;
         if (mem_rd) rd_cnt++;
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic setup_desc(input int idx, input int base, input int cnt,
                             input bit eof, input bit own, input int seed);
      int nw;
      nw = (cnt + 3) / 4;
      for (int w = 0; w < nw; w++) begin
         logic [31:0] word;
         word = '0;
         for (int l = 0; l < 4; l++)
            if (w * 4 + l < cnt) word[8*l +: 8] = pat(seed, w * 4 + l);
         mem[base + w] <= word;
      end
      for (int j = 0; j < cnt; j++)
         exp_q.push_back({eof && (j == cnt - 1), pat(seed, j)});
      mem[RB + 2 * idx + 1] <= 32'(base);
      mem[RB + 2 * idx]     <= ctl(own, eof, cnt);
   endtask

   task automatic wait_idx(input int exp, input string req);
      int n;
      n = 0;
      while ((int'(cur_idx) != exp || exp_q.size() != 0) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(int'(cur_idx) == exp, req, "current index", int'(cur_idx), exp);
      chk(exp_q.size() == 0, req, "bytes left", exp_q.size(), 0);
   endtask

   task automatic chk_ctl(input int idx, input bit eof, input int cnt, input string req);
      chk(mem[RB + 2 * idx] == ctl(1'b0, eof, cnt), req, "handed-back control word",
          int'(mem[RB + 2 * idx]), int'(ctl(1'b0, eof, cnt)));
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      repeat (3) @(negedge clk);
      // reset state
      chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
      chk(cur_idx == 2'd0, "R7", "index at reset", int'(cur_idx), 0);
      chk(err_flag == 1'b0, "R8", "error at reset", int'(err_flag), 0);
      chk(tx_valid == 1'b0, "R5", "valid at reset", int'(tx_valid), 0);
      rst_n = 1'b1;

      // R1: owned descriptor waits while either gating flag is low
      setup_desc(0, 64, 5, 1'b1, 1'b1, 1);
      gate_off = 1'b1;
      chan_active = 1'b1; tx_ready = 1'b0;
      repeat (40) @(negedge clk);
      chan_active = 1'b0; tx_ready = 1'b1;
      repeat (40) @(negedge clk);
      chk(gated_rd == 0, "R1", "reads while gated", gated_rd, 0);
      chk(exp_q.size() == 5, "R1", "bytes held back", exp_q.size(), 5);
      chk(cur_idx == 2'd0, "R1", "index while gated", int'(cur_idx), 0);
      gate_off = 1'b0;

      // R2 R4 R6 R7: single descriptor frame
      chan_active = 1'b1;
      wait_idx(1, "R7");
      chk_ctl(0, 1'b1, 5, "R6");

      // R5: frame chained over two descriptors
      setup_desc(1, 80, 3, 1'b0, 1'b1, 2);
      setup_desc(2, 96, 6, 1'b1, 1'b1, 3);
      wait_idx(3, "R5");
      chk_ctl(1, 1'b0, 3, "R6");
      chk_ctl(2, 1'b1, 6, "R6");

      // R7: wrap from the last ring entry
      setup_desc(3, 112, 2, 1'b1, 1'b1, 4);
      wait_idx(0, "R7");
      chk_ctl(3, 1'b1, 2, "R6");

      // R2 R3: unowned descriptor is polled with back-off
      setup_desc(0, 128, 4, 1'b1, 1'b0, 5);
      @(negedge clk);
      rd_cnt = 0;
      repeat (100) @(negedge clk);
      chk(rd_cnt <= 100 / (GAP + 1) + 1, "R3", "poll reads upper bound", rd_cnt, 100 / (GAP + 1) + 1);
      chk(rd_cnt >= 1, "R3", "poll reads lower bound", rd_cnt, 1);
      chk(exp_q.size() == 4, "R2", "no bytes while unowned", exp_q.size(), 4);
      mem[RB] <= ctl(1'b1, 1'b1, 4);
      wait_idx(1, "R3");

      // R9: chained descriptor withheld mid-frame
      setup_desc(1, 144, 2, 1'b0, 1'b1, 6);
      setup_desc(2, 160, 1, 1'b1, 1'b0, 7);
      repeat (60) @(negedge clk);
      chk(exp_q.size() == 1, "R9", "bytes pending mid-frame", exp_q.size(), 1);
      chk(busy == 1'b1, "R9", "busy while stalled", int'(busy), 1);
      chk(cur_idx == 2'd1, "R9", "index while stalled", int'(cur_idx), 1);
      mem[RB + 4] <= ctl(1'b1, 1'b1, 1);
      wait_idx(3, "R9");
      chk(aborts == 0, "R9", "aborts", aborts, 0);
      chk_ctl(2, 1'b1, 1, "R6");

      // R8: zero byte count after a good descriptor (crossing the wrap)
      setup_desc(0, 176, 0, 1'b1, 1'b1, 8);
      setup_desc(3, 192, 2, 1'b0, 1'b1, 9);
      wait_idx(1, "R8");
      chk(aborts == 1, "R8", "abort pulses", aborts, 1);
      chk(err_flag == 1'b1, "R8", "error flag", int'(err_flag), 1);
      chk_ctl(3, 1'b0, 2, "R8");
      chk_ctl(0, 1'b1, 0, "R8");
      repeat (30) @(negedge clk);
      chk(err_flag == 1'b1, "R8", "error stays set", int'(err_flag), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule